// File: doc/BRIEF.md
# Parallel EEPROM Write Sequencer

This block is a clocked host-side master for a byte-wide nonvolatile memory that is read and written like a static RAM. A request is accepted through a valid/ready handshake and carries a direction, an address and, for writes, a data byte. A read holds chip select and output enable low for a parameterised number of cycles, then samples the data bus. A write sets up the address, pulses write enable low while driving the data, holds the data for one more cycle, and then waits for the memory's self-timed internal programming to finish.

The end of programming is detected by one of two methods, chosen per request by a mode input sampled at acceptance. The first watches a ready/busy level from the memory. The second repeatedly reads back the written address until bit 7 of the returned byte equals bit 7 of the byte that was written. A cycle counter bounds the wait. If the end is not seen in time, the operation ends with an error flag. Every operation ends with a one-cycle done pulse. No new request is accepted before that pulse. All bus timing is counted in clock cycles.

Top module: `nvm_write_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `req_ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1, `dq_oe` is 0 and `done` is 0.
- R2: A read (`req_write`=0) holds `mem_ce_n`=0 and `mem_oe_n`=0 with `mem_we_n`=1 for exactly RD_CYCLES consecutive cycles. It returns in `rd_data` the `dq_i` byte from the last of them, and gives one `done` cycle with `resp_err`=0.
- R3: A write (`req_write`=1) gives one setup cycle with `mem_ce_n`=0 and `mem_we_n`=1, then exactly WE_CYCLES cycles of `mem_we_n`=0, then one hold cycle with `mem_we_n`=1. Throughout these cycles `mem_ce_n`=0 and `mem_oe_n`=1.
- R4: During the whole write access, `mem_addr` equals the accepted address. `dq_o` equals the accepted data byte whenever `dq_oe` is 1, and both stay stable while `mem_we_n` is low.
- R5: `dq_oe` is 1 only during the write pulse and the hold cycle that follows it, which is WE_CYCLES+1 cycles per write. It is never 1 while `mem_oe_n` is 0.
- R6: In ready/busy mode (`poll_mode`=0 at acceptance), after the hold cycle the bus stays idle with no read access. `done` follows in the first wait cycle in which `mem_rdy` is 1. A change of `poll_mode` after acceptance has no effect.
- R7: In polling mode (`poll_mode`=1 at acceptance), after the hold cycle the block repeats one idle cycle followed by one RD_CYCLES read of the same address. It ends with `resp_err`=0 at the first read whose `dq_i` bit 7 equals bit 7 of the written byte.
- R8: If completion is not seen in any of the first TIMEOUT_CYCLES wait cycles after the hold cycle, the block gives `done` with `resp_err`=1 in the cycle after the last of them.
- R9: When completion and the last permitted wait cycle coincide, completion wins and `resp_err` is 0.
- R10: `req_ready` is 0 from the cycle after acceptance through the `done` cycle, and `req_ready` returns to 1 in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | 8 | Byte to write |
| poll_mode | input | 1 | Completion method: 1 = bit-7 polling, 0 = ready/busy |
| done | output | 1 | One-cycle end-of-operation pulse |
| resp_err | output | 1 | Completion wait expired (valid with done) |
| rd_data | output | 8 | Byte returned by the last read |
| mem_addr | output | AW | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| dq_o | output | 8 | Data bus drive value |
| dq_oe | output | 1 | Data bus driver enable (0 = high impedance) |
| dq_i | input | 8 | Data bus sampled value |
| mem_rdy | input | 1 | Memory ready (1) or busy programming (0) |

## Verification
Completion detection and timeout expiry can both fall in the last permitted wait cycle. The bench provokes this with its memory model in ready/busy mode. It sets the busy time to exactly one cycle less than the limit, which must end cleanly, and to exactly the limit, which must end with the error flag. Polling writes use busy times that give a single matching read, several mismatching reads, and an expiry. Each write is then read back to confirm the byte that was latched on the rising edge of the write pulse.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_WAIT_RB,
        ST_POLL_GAP,
        ST_POLL_RD,
        ST_RESP
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } bus_ctl_t;

endpackage

// File: rtl/nvm_bus_decode.sv
module nvm_bus_decode
    import nvm_seq_pkg::*;
(
    input  seq_state_e state,
    output bus_ctl_t   ctl
);
    always_comb begin
        ctl = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
        case (state)
            ST_RD, ST_POLL_RD: begin
                ctl.ce_n = 1'b0;
                ctl.oe_n = 1'b0;
            end
            ST_WR_SETUP: ctl.ce_n = 1'b0;
            ST_WR_PULSE: begin
                ctl.ce_n  = 1'b0;
                ctl.we_n  = 1'b0;
                ctl.dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                ctl.ce_n  = 1'b0;
                ctl.dq_oe = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nvm_end_detect.sv
module nvm_end_detect (
    input  logic poll_sel,
    input  logic rdy_level,
    input  logic sample_now,
    input  logic read_bit7,
    input  logic want_bit7,
    output logic complete
);
    // Polling: completion only counts at the sampling cycle of a read.
    always_comb begin
        if (poll_sel) complete = sample_now && (read_bit7 == want_bit7);
        else          complete = rdy_level;
    end
endmodule

// File: rtl/nvm_write_seq.sv
module nvm_write_seq
    import nvm_seq_pkg::*;
#(
    parameter int AW             = 13,
    parameter int WE_CYCLES      = 20,     // write pulse width, >= 1
    parameter int RD_CYCLES      = 24,     // read access wait, >= 1
    parameter int TIMEOUT_CYCLES = 200000  // completion wait limit, >= 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_wdata,
    input  logic          poll_mode,
    output logic          done,
    output logic          resp_err,
    output logic [7:0]    rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [7:0]    dq_o,
    output logic          dq_oe,
    input  logic [7:0]    dq_i,
    input  logic          mem_rdy
);
    localparam int TMAX = (WE_CYCLES > RD_CYCLES) ? WE_CYCLES : RD_CYCLES;
    localparam int TCW  = $clog2(TMAX + 1);
    localparam int WCW  = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TCW-1:0] WE_LAST = TCW'(WE_CYCLES - 1);
    localparam logic [TCW-1:0] RD_LAST = TCW'(RD_CYCLES - 1);
    localparam logic [WCW-1:0] TO_LAST = WCW'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] addr;
        logic [7:0]    wdata;
        logic          poll;
        logic [TCW-1:0] tcnt;
        logic [WCW-1:0] wcnt;
        logic          err;
        logic [7:0]    rdata;
    } regs_t;

    regs_t    q, d;
    bus_ctl_t ctl;
    logic     complete;
    logic     sample_now;

    assign sample_now = (q.st == ST_POLL_RD) && (q.tcnt == RD_LAST);

    nvm_bus_decode u_dec (
        .state (q.st),
        .ctl   (ctl)
    );

    nvm_end_detect u_end (
        .poll_sel   (q.poll),
        .rdy_level  (mem_rdy),
        .sample_now (sample_now),
        .read_bit7  (dq_i[7]),
        .want_bit7  (q.wdata[7]),
        .complete   (complete)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.poll  = poll_mode;
                    d.err   = 1'b0;
                    d.tcnt  = '0;
                    d.st    = req_write ? ST_WR_SETUP : ST_RD;
                end
            end
            ST_RD: begin
                if (q.tcnt == RD_LAST) begin
                    d.rdata = dq_i;
                    d.st    = ST_RESP;
                end else begin
                    d.tcnt = q.tcnt + 1'b1;
                end
            end
            ST_WR_SETUP: begin
                d.tcnt = '0;
                d.st   = ST_WR_PULSE;
            end
            ST_WR_PULSE: begin
                if (q.tcnt == WE_LAST) d.st = ST_WR_HOLD;
                else                   d.tcnt = q.tcnt + 1'b1;
            end
            ST_WR_HOLD: begin
                d.wcnt = '0;
                d.tcnt = '0;
                d.st   = q.poll ? ST_POLL_GAP : ST_WAIT_RB;
            end
            ST_WAIT_RB: begin
                if (complete) begin
                    d.st = ST_RESP;
                end else if (q.wcnt == TO_LAST) begin
                    d.err = 1'b1;
                    d.st  = ST_RESP;
                end else begin
                    d.wcnt = q.wcnt + 1'b1;
                end
            end
            ST_POLL_GAP: begin
                if (q.wcnt == TO_LAST) begin
                    d.err = 1'b1;
                    d.st  = ST_RESP;
                end else begin
                    d.wcnt = q.wcnt + 1'b1;
                    d.tcnt = '0;
                    d.st   = ST_POLL_RD;
                end
            end
            ST_POLL_RD: begin
                if (complete) begin
                    d.st = ST_RESP;
                end else if (q.wcnt == TO_LAST) begin
                    d.err = 1'b1;
                    d.st  = ST_RESP;
                end else begin
                    d.wcnt = q.wcnt + 1'b1;
                    if (q.tcnt == RD_LAST) begin
                        d.tcnt = '0;
                        d.st   = ST_POLL_GAP;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            ST_RESP: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.st == ST_IDLE);
    assign done      = (q.st == ST_RESP);
    assign resp_err  = done && q.err;
    assign rd_data   = q.rdata;
    assign mem_addr  = q.addr;
    assign dq_o      = q.wdata;
    assign mem_ce_n  = ctl.ce_n;
    assign mem_oe_n  = ctl.oe_n;
    assign mem_we_n  = ctl.we_n;
    assign dq_oe     = ctl.dq_oe;
endmodule

// File: rtl/nvm_write_seq_chk.sv
module nvm_write_seq_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          done,
    input logic          resp_err,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [7:0]    dq_o,
    input logic          dq_oe
);
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !dq_oe));

    p_we_oe_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));

    p_data_at_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> dq_oe);

    p_pulse_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(dq_o)));

    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (mem_oe_n && !mem_ce_n));

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> done);

    p_busy_in_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);
endmodule

bind nvm_write_seq nvm_write_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .resp_err  (resp_err),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .dq_o      (dq_o),
    .dq_oe     (dq_oe)
);

// File: tb/nvm_write_seq_tb.sv
`timescale 1ns/1ps
module nvm_write_seq_tb;
    localparam int AW  = 6;
    localparam int WE  = 3;
    localparam int RD  = 2;
    localparam int TO  = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_wdata = '0;
    logic          poll_mode = 1'b0;
    logic          done, resp_err;
    logic [7:0]    rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, dq_oe;
    logic [7:0]    dq_o, dq_i;
    logic          mem_rdy;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    nvm_write_seq #(.AW(AW), .WE_CYCLES(WE), .RD_CYCLES(RD), .TIMEOUT_CYCLES(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .poll_mode(poll_mode), .done(done), .resp_err(resp_err), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i), .mem_rdy(mem_rdy)
    );

    // Memory model: latches data at the rising edge of the write pulse,
    // then stays busy for busy_len cycles, inverting bit 7 on reads meanwhile.
    logic [7:0] mdl_mem [64];
    logic [7:0] exp_mem [64];
    int         busy_cnt;
    int         busy_len = 0;
    logic       prev_we;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= 0;
            prev_we  <= 1'b1;
        end else begin
            prev_we <= mem_we_n;
            if (!prev_we && mem_we_n) begin
                busy_cnt <= busy_len;
                if (dq_oe) mdl_mem[mem_addr] <= dq_o;
            end else if (busy_cnt > 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end

    assign mem_rdy = (busy_cnt == 0);
    assign dq_i = (!mem_ce_n && !mem_oe_n)
                ? ((busy_cnt != 0) ? {~mdl_mem[mem_addr][7], mdl_mem[mem_addr][6:0]}
                                   : mdl_mem[mem_addr])
                : 8'h00;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Issue one request and observe the bus at negedges until done.
    task automatic run_op(input logic wr, input logic [AW-1:0] a, input logic [7:0] dat,
                          input logic pm, input int blen,
                          output logic got_err, output logic [7:0] got_rd,
                          output int we_len, output int bursts, output int oe_len,
                          output int drv, output int bad, output int rdy_hi);
        logic prev_rd;
        busy_len = blen;
        we_len = 0; bursts = 0; oe_len = 0; drv = 0; bad = 0; rdy_hi = 0;
        got_err = 1'b0; got_rd = 8'h00; prev_rd = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat; poll_mode = pm;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        poll_mode = ~pm;  // must have no effect after acceptance
        for (int i = 0; i < 5000; i++) begin
            if (!mem_we_n) we_len++;
            if (!mem_ce_n && !mem_oe_n) begin
                if (!prev_rd) begin bursts++; oe_len = 0; end
                oe_len++;
                if (mem_addr != a) bad++;
                prev_rd = 1'b1;
            end else begin
                prev_rd = 1'b0;
            end
            if (dq_oe) begin
                drv++;
                if (mem_addr != a || dq_o != dat) bad++;
            end
            if (!mem_ce_n && mem_addr != a) bad++;
            if (req_ready) rdy_hi++;
            if (done) begin
                got_err = resp_err;
                got_rd  = rd_data;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after done", int'(req_ready), 1);
        chk(rdy_hi == 0, "R10 ready low during op", rdy_hi, 0);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] dat, input logic pm,
                            input int blen, input logic exp_err);
        logic e; logic [7:0] r; int wl, bu, ol, dr, bd, rh;
        run_op(1'b1, a, dat, pm, blen, e, r, wl, bu, ol, dr, bd, rh);
        exp_mem[a] = dat;
        chk(e == exp_err, pm ? "R7/R8 poll write err" : "R6/R8/R9 rdy write err",
            int'(e), int'(exp_err));
        chk(wl == WE, "R3 write pulse width", wl, WE);
        chk(dr == WE + 1, "R5 drive window", dr, WE + 1);
        chk(bd == 0, "R4 addr/data on bus", bd, 0);
        if (!pm) chk(bu == 0, "R6 no reads while waiting", bu, 0);
        else if (!exp_err && blen == 0) chk(bu == 1, "R7 single poll read", bu, 1);
        else if (!exp_err && blen > 3 * (RD + 1)) chk(bu >= 2, "R7 repeated poll reads", bu, 2);
        while (busy_cnt != 0) @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        logic e; logic [7:0] r; int wl, bu, ol, dr, bd, rh;
        run_op(1'b0, a, 8'h00, 1'b0, 0, e, r, wl, bu, ol, dr, bd, rh);
        chk(r == exp_mem[a], "R2 read data", int'(r), int'(exp_mem[a]));
        chk(e == 1'b0, "R2 read no err", int'(e), 0);
        chk(bu == 1 && ol == RD, "R2 read access length", ol, RD);
        chk(wl == 0 && dr == 0, "R2/R5 no write activity on read", wl + dr, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) begin
            mdl_mem[i] = 8'($urandom);
            exp_mem[i] = mdl_mem[i];
        end
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1 && mem_ce_n && mem_oe_n && mem_we_n && !dq_oe && !done,
            "R1 reset state", {req_ready, mem_ce_n, mem_oe_n, mem_we_n, dq_oe, done}, 6'b111100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !dq_oe && !done,
            "R1 idle after reset", int'(req_ready), 1);

        // Directed cases
        do_read(6'd5);
        do_write(6'd5, 8'hA5, 1'b0, 10, 1'b0);
        do_read(6'd5);
        do_write(6'd6, 8'h3C, 1'b1, 0, 1'b0);
        do_read(6'd6);
        do_write(6'd7, 8'h81, 1'b1, 25, 1'b0);
        do_read(6'd7);
        do_write(6'd8, 8'h11, 1'b0, TO - 1, 1'b0);  // R9 coincidence
        do_write(6'd9, 8'h22, 1'b0, TO, 1'b1);      // R8 expiry
        do_write(6'd10, 8'h7F, 1'b1, 200, 1'b1);    // R8 expiry in polling
        do_read(6'd8);
        do_read(6'd9);
        do_read(6'd10);

        // Random mix
        for (int i = 0; i < 40; i++) begin
            logic [AW-1:0] a;
            logic pm;
            a  = AW'($urandom_range(0, 63));
            pm = 1'($urandom);
            if ($urandom_range(0, 1) == 0) do_read(a);
            else if (pm) do_write(a, 8'($urandom), 1'b1,
                                  ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(10, 40), 1'b0);
            else do_write(a, 8'($urandom), 1'b0, $urandom_range(0, 40), 1'b0);
        end
        for (int i = 0; i < 8; i++) do_read(AW'(i * 7));

        summary();
        $finish;
    end
endmodule